// File: doc/BRIEF.md
# Display Control Register File

This block holds the mode settings of a simple linear-framebuffer display controller and makes them reachable over a small memory-mapped slave port. A bus master writes resolution, pixel depth, virtual line width, panning offsets and an enable word into 16-bit registers. Downstream scan-out logic takes those values straight from the block's output ports. Two read-only entries report a fixed version code and the framebuffer size. They are produced when read and have no storage behind them.

The address space is split by its top bit. With the top bit clear, the access goes to the mode bank, and the halfword index is the byte address shifted right by one. With the top bit set, the access goes to a small 32-bit extended window. That window reports its own size and holds a framebuffer byte-order flag. The flag changes only when one of two exact 32-bit key values is written. Read data is registered and appears one cycle after the read strobe.

Top module: `dispctl_regs`

## Requirements
- R1: After reset every mode output is zero, `fb_big_endian` is 0 and `rdata` is zero.
- R2: With `addr[9]`=0, the halfword index is `addr[8:1]` (bit 0 is ignored). A write at index 1 to 7 stores `wdata[15:0]`, and a later read at that index returns it zero-extended. Read data appears in the cycle after `rd` is sampled.
- R3: A read at index 0 always returns `ID_VALUE` (default 0xB0C5). A write there changes no output.
- R4: A read at index 8 returns `FB_BYTES` / 65536. With the default 16 MiB this is 256. A write there changes no output.
- R5: A read at any index from 9 to 255 returns 0x0000FFFF. A write at such an index is dropped and changes no output.
- R6: With `addr[9]`=1, the window offset is `addr[8:0]`. Offset 0 reads 8, the window's byte size. Every offset other than 0 and 4 reads 0.
- R7: A write at window offset 4 with data exactly 0xBEBEBEBE sets `fb_big_endian`. A write with data exactly 0x1E1E1E1E clears it.
- R8: A write at window offset 4 with any other data leaves `fb_big_endian` unchanged. Writes at other window offsets change nothing.
- R9: A read at window offset 4 returns 0xBEBEBEBE while big-endian is selected and 0x1E1E1E1E otherwise.
- R10: The mode outputs follow indices 1 to 7 in this order: enable, bpp, xres, yres, virt_width, x_off, y_off. Each one updates in the cycle after its write, and without a write every output holds its value.
- R11: `rdata` keeps its last value in any cycle without `rd`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| addr | input | 10 | Byte address; bit 9 selects the extended window |
| wr | input | 1 | Write strobe |
| wdata | input | 32 | Write data |
| rd | input | 1 | Read strobe |
| rdata | output | 32 | Registered read data |
| mode_enable | output | 16 | Enable word |
| mode_bpp | output | 16 | Bits per pixel |
| mode_xres | output | 16 | Horizontal resolution |
| mode_yres | output | 16 | Vertical resolution |
| mode_vwidth | output | 16 | Virtual line width |
| mode_xoff | output | 16 | Horizontal pan offset |
| mode_yoff | output | 16 | Vertical pan offset |
| fb_big_endian | output | 1 | Framebuffer byte order, 1 = big-endian |

## Verification
The bench writes a distinct index-derived value to every halfword of the mode bank, then reads back every byte address, odd ones included. This separates stored entries from synthesized ones and from out-of-range ones, and it shows that bit 0 is ignored. The mode outputs are then compared against a bench model. That comparison shows that writes to index 0, index 8 and out-of-range indices leaked nowhere. A second write through an odd address confirms that bit 0 is dropped on writes too. The extended window is swept at every offset, and the byte-order flag is driven with both keys, with near-miss keys and with writes at wrong offsets. This separates exact-match behaviour from loose decoding.

// File: rtl/dispctl_regs.sv
module dispctl_regs #(
  parameter int          ADDR_W   = 10,
  parameter int          FB_BYTES = 16 * 1024 * 1024,
  parameter logic [15:0] ID_VALUE = 16'hB0C5,
  parameter logic [31:0] KEY_BE   = 32'hBEBEBEBE,
  parameter logic [31:0] KEY_LE   = 32'h1E1E1E1E
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wr,
  input  logic [31:0]       wdata,
  input  logic              rd,
  output logic [31:0]       rdata,
  output logic [15:0]       mode_enable,
  output logic [15:0]       mode_bpp,
  output logic [15:0]       mode_xres,
  output logic [15:0]       mode_yres,
  output logic [15:0]       mode_vwidth,
  output logic [15:0]       mode_xoff,
  output logic [15:0]       mode_yoff,
  output logic              fb_big_endian
);
  localparam int IDX_W     = ADDR_W - 2;
  localparam int OFF_W     = ADDR_W - 1;
  localparam int IDX_ID    = 0;
  localparam int IDX_FIRST = 1;
  localparam int IDX_LAST  = 7;
  localparam int IDX_MEM   = 8;
  localparam int NREG      = 9;
  localparam int EXT_BYTES = 8;
  localparam int OFF_SIZE  = 0;
  localparam int OFF_BO    = 4;
  localparam logic [15:0] MEM_UNITS = 16'(FB_BYTES / 65536);

  logic             ext_sel;
  logic [IDX_W-1:0] idx;
  logic [OFF_W-1:0] off;
  logic [15:0]      mreg [IDX_FIRST:IDX_LAST];
  logic             be_q;
  logic [31:0]      rmux;

  assign ext_sel = addr[ADDR_W-1];
  assign idx     = addr[ADDR_W-2:1];
  assign off     = addr[OFF_W-1:0];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = IDX_FIRST; i <= IDX_LAST; i++) mreg[i] <= '0;
    end else if (wr && !ext_sel) begin
      for (int i = IDX_FIRST; i <= IDX_LAST; i++)
        if (int'(idx) == i) mreg[i] <= wdata[15:0];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) be_q <= 1'b0;
    else if (wr && ext_sel && int'(off) == OFF_BO) begin
      if (wdata == KEY_BE)      be_q <= 1'b1;
      else if (wdata == KEY_LE) be_q <= 1'b0;
    end
  end

  always_comb begin
    rmux = '0;
    if (ext_sel) begin
      if (int'(off) == OFF_SIZE)    rmux = 32'(EXT_BYTES);
      else if (int'(off) == OFF_BO) rmux = be_q ? KEY_BE : KEY_LE;
    end else begin
      if (int'(idx) == IDX_ID)       rmux = {16'h0, ID_VALUE};
      else if (int'(idx) == IDX_MEM) rmux = {16'h0, MEM_UNITS};
      else if (int'(idx) >= NREG)    rmux = 32'h0000_FFFF;
      else begin
        for (int i = IDX_FIRST; i <= IDX_LAST; i++)
          if (int'(idx) == i) rmux = {16'h0, mreg[i]};
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)  rdata <= '0;
    else if (rd) rdata <= rmux;
  end

  assign mode_enable   = mreg[1];
  assign mode_bpp      = mreg[2];
  assign mode_xres     = mreg[3];
  assign mode_yres     = mreg[4];
  assign mode_vwidth   = mreg[5];
  assign mode_xoff     = mreg[6];
  assign mode_yoff     = mreg[7];
  assign fb_big_endian = be_q;
endmodule

// File: rtl/dispctl_regs_chk.sv
module dispctl_regs_chk #(
  parameter int          ADDR_W   = 10,
  parameter int          FB_BYTES = 16 * 1024 * 1024,
  parameter logic [15:0] ID_VALUE = 16'hB0C5,
  parameter logic [31:0] KEY_BE   = 32'hBEBEBEBE,
  parameter logic [31:0] KEY_LE   = 32'h1E1E1E1E
) (
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] addr,
  input logic              wr,
  input logic [31:0]       wdata,
  input logic              rd,
  input logic [31:0]       rdata,
  input logic [15:0]       mode_enable,
  input logic [15:0]       mode_bpp,
  input logic [15:0]       mode_xres,
  input logic [15:0]       mode_yres,
  input logic [15:0]       mode_vwidth,
  input logic [15:0]       mode_xoff,
  input logic [15:0]       mode_yoff,
  input logic              fb_big_endian
);
  logic [ADDR_W-3:0] idx;
  logic              ext;
  logic              bo_hit;
  logic [111:0]      outs;

  assign idx    = addr[ADDR_W-2:1];
  assign ext    = addr[ADDR_W-1];
  assign bo_hit = ext && int'(addr[ADDR_W-2:0]) == 4;
  assign outs   = {mode_enable, mode_bpp, mode_xres, mode_yres,
                   mode_vwidth, mode_xoff, mode_yoff};

  a_r3_id_fixed: assert property (@(posedge clk) disable iff (!rst_n)
    rd && !ext && idx == '0 |=> rdata == {16'h0, ID_VALUE});

  a_r5_unstored_write_dropped: assert property (@(posedge clk) disable iff (!rst_n)
    wr && !ext && (int'(idx) == 0 || int'(idx) >= 8) |=> $stable(outs));

  a_r5_oor_reads_ones: assert property (@(posedge clk) disable iff (!rst_n)
    rd && !ext && int'(idx) >= 9 |=> rdata == 32'h0000_FFFF);

  a_r7_key_be: assert property (@(posedge clk) disable iff (!rst_n)
    wr && bo_hit && wdata == KEY_BE |=> fb_big_endian);

  a_r7_key_le: assert property (@(posedge clk) disable iff (!rst_n)
    wr && bo_hit && wdata == KEY_LE |=> !fb_big_endian);

  a_r8_bo_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr && bo_hit && (wdata == KEY_BE || wdata == KEY_LE)) |=> $stable(fb_big_endian));

  a_r9_bo_read: assert property (@(posedge clk) disable iff (!rst_n)
    rd && bo_hit |=> rdata == ($past(fb_big_endian) ? KEY_BE : KEY_LE));

  a_r10_idle_stable: assert property (@(posedge clk) disable iff (!rst_n)
    !wr |=> $stable(outs));

  a_r11_rdata_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !rd |=> $stable(rdata));
endmodule

bind dispctl_regs dispctl_regs_chk #(
  .ADDR_W(ADDR_W), .FB_BYTES(FB_BYTES), .ID_VALUE(ID_VALUE),
  .KEY_BE(KEY_BE), .KEY_LE(KEY_LE)
) u_chk (
  .clk(clk), .rst_n(rst_n), .addr(addr), .wr(wr), .wdata(wdata), .rd(rd),
  .rdata(rdata), .mode_enable(mode_enable), .mode_bpp(mode_bpp),
  .mode_xres(mode_xres), .mode_yres(mode_yres), .mode_vwidth(mode_vwidth),
  .mode_xoff(mode_xoff), .mode_yoff(mode_yoff), .fb_big_endian(fb_big_endian)
);

// File: tb/sim_dispctl_regs.sv
module sim_dispctl_regs;
  localparam int CLK_PERIOD = 10;
  localparam logic [31:0] BE = 32'hBEBEBEBE;
  localparam logic [31:0] LE = 32'h1E1E1E1E;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [9:0]  addr = '0;
  logic        wr = 1'b0;
  logic [31:0] wdata = '0;
  logic        rd = 1'b0;
  logic [31:0] rdata;
  logic [15:0] m_en, m_bpp, m_xr, m_yr, m_vw, m_xo, m_yo;
  logic        be;

  int tests = 0;
  int fails = 0;
  bit done = 0;
  logic [15:0] model [1:7];

  always #(CLK_PERIOD / 2) clk = ~clk;

  dispctl_regs u0 (
    .clk(clk), .rst_n(rst_n), .addr(addr), .wr(wr), .wdata(wdata), .rd(rd),
    .rdata(rdata), .mode_enable(m_en), .mode_bpp(m_bpp), .mode_xres(m_xr),
    .mode_yres(m_yr), .mode_vwidth(m_vw), .mode_xoff(m_xo), .mode_yoff(m_yo),
    .fb_big_endian(be)
  );

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic bus_wr(logic [9:0] a, logic [31:0] d);
    @(negedge clk); addr = a; wdata = d; wr = 1'b1;
    @(negedge clk); wr = 1'b0;
  endtask

  task automatic bus_rd(logic [9:0] a);
    @(negedge clk); addr = a; rd = 1'b1;
    @(negedge clk); rd = 1'b0;
  endtask

  function automatic logic [31:0] exp_mode(int i);
    if (i == 0) return 32'h0000_B0C5;
    if (i == 8) return 32'd256;
    if (i >= 9) return 32'h0000_FFFF;
    return {16'h0, model[i]};
  endfunction

  task automatic check_outs(string req);
    check(req, {16'h0, m_en}, {16'h0, model[1]});
    check(req, {16'h0, m_bpp}, {16'h0, model[2]});
    check(req, {16'h0, m_xr}, {16'h0, model[3]});
    check(req, {16'h0, m_yr}, {16'h0, model[4]});
    check(req, {16'h0, m_vw}, {16'h0, model[5]});
    check(req, {16'h0, m_xo}, {16'h0, model[6]});
    check(req, {16'h0, m_yo}, {16'h0, model[7]});
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      tests++; fails++;
      $display("FAIL watchdog: actual running expected done");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    for (int i = 1; i <= 7; i++) model[i] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    check_outs("R1");
    check("R1 be", {31'h0, be}, 32'h0);
    check("R1 rdata", rdata, 32'h0);

    // R2 R3 R4 R5: write every halfword index with its own value
    for (int i = 0; i < 256; i++) begin
      logic [15:0] d;
      d = 16'((i * 291 + 7) ^ 16'hA5C3);
      bus_wr(10'(2 * i), {16'hDEAD, d});
      if (i >= 1 && i <= 7) model[i] = d;
    end
    // R10 outputs mirror stored indices, nothing leaked from 0, 8 or 9+
    check_outs("R10 R5 R3 R4");
    // sweep every byte address including odd ones (R2 bit 0 ignored)
    for (int a = 0; a < 512; a++) begin
      bus_rd(10'(a));
      if (a / 2 == 0)      check("R3", rdata, exp_mode(0));
      else if (a / 2 == 8) check("R4", rdata, exp_mode(8));
      else if (a / 2 >= 9) check("R5", rdata, exp_mode(a / 2));
      else                 check("R2", rdata, exp_mode(a / 2));
    end
    // R2 odd-address write lands on same index
    bus_wr(10'd7, 32'h0000_1234);
    model[3] = 16'h1234;
    check("R10 xres", {16'h0, m_xr}, 32'h1234);
    bus_rd(10'd6);
    check("R2 odd write", rdata, 32'h1234);
    // R11 rdata holds without rd
    repeat (3) @(negedge clk);
    check("R11", rdata, 32'h1234);

    // R6 extended window sweep
    for (int o = 0; o < 512; o++) begin
      bus_rd(10'(512 + o));
      if (o == 0)      check("R6 size", rdata, 32'd8);
      else if (o == 4) check("R9", rdata, LE);
      else             check("R6", rdata, 32'h0);
    end

    // R7 R8 R9 byte order
    bus_wr(10'd516, BE);
    check("R7 set", {31'h0, be}, 32'h1);
    bus_rd(10'd516);
    check("R9 be", rdata, BE);
    bus_wr(10'd516, 32'hBEBEBEBF);
    check("R8 near miss", {31'h0, be}, 32'h1);
    bus_wr(10'd516, 32'h0);
    check("R8 zero", {31'h0, be}, 32'h1);
    bus_wr(10'd520, LE);
    check("R8 wrong offset", {31'h0, be}, 32'h1);
    bus_wr(10'd4, LE);
    check("R8 mode window", {31'h0, be}, 32'h1);
    bus_wr(10'd516, LE);
    check("R7 clear", {31'h0, be}, 32'h0);
    bus_wr(10'd516, 32'h1E1E1E1F);
    check("R8 near miss le", {31'h0, be}, 32'h0);
    bus_wr(10'd516, BE);
    bus_wr(10'd516, 32'h1E1E_0000);
    check("R8 partial", {31'h0, be}, 32'h1);
    bus_rd(10'd516);
    check("R9 be hold", rdata, BE);
    // mode window write via index 2 mirrors only into index 2 (with leftover effect of 10'd4 write)
    model[2] = LE[15:0];
    check_outs("R10 final");

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule